// File: doc/BRIEF.md
# Toggle-on-write interrupt register bank

This block gathers the interrupt events of a peripheral core into one bank of registers on a plain 32-bit read/write strobe bus. It has a pending-status register, a per-bit enable register, a global enable bit and a keyed device-reset register. A single level interrupt line goes high when the global enable is set and at least one pending bit is also enabled.

Software uses one register to raise and to acknowledge interrupts. Writing a 1 to a status bit inverts that bit and writing a 0 leaves it alone. Writing the same mask twice therefore first forces the bits and then clears them. The core supplies the reset value of every status bit, so some bits can already be pending when reset ends. A rising edge on an event input latches its status bit. The bit stays set until software toggles it or the device is reset.

The number of implemented bits is set by `NUM_BITS`, from 0 to 32 (default 8). The implemented bits start at bit 0.

Top module: `irq_toggle_bank`

## Requirements
- R1: Only bits 0 to NUM_BITS-1 are implemented (NUM_BITS = 8 by default; 0 means none). In the status and enable registers, bits at and above NUM_BITS always read 0 and ignore writes.
- R2: The enable register at byte offset 0x0C resets to 0. A read of it returns the last written value, limited to the implemented bits.
- R3: A write to the status register at offset 0x08 inverts every status bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R4: While rstN is low, each status bit loads the matching bit of the statusInit input.
- R5: A set status bit stays set until a status write toggles it or a device reset reloads it. A falling or steady event input never clears it.
- R6: A 0-to-1 transition of eventIn[i] between consecutive clock edges sets status bit i. If that transition and a status write toggling bit i fall in the same cycle, the bit ends up set. An event level already high before a reset produces no new edge afterwards.
- R7: The global enable is bit 0 at offset 0x04 and resets to 0. irqOut is 1 exactly when the global enable is 1 and some status bit and its enable bit are both 1. irqOut follows the register state in the same cycle.
- R8: Writing 0x0000000A to offset 0x00 produces a one-cycle internal reset in the following cycle. At the end of that cycle the enables and the global enable are 0 and status equals statusInit. Any other value written there has no effect.
- R9: A read strobe loads rdData at the clock edge, so the value is visible in the next cycle. rdData holds its value while no read is strobed. Offset 0x00 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| eventIn | input | 32 | Interrupt event levels from the core; bits above NUM_BITS unused |
| statusInit | input | 32 | Reset value of the status bits |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Two functions can act on the same status bit in one cycle: a software toggle write and a rising event from the core. The bench first sets a bit by writing it. It then drives a toggle write for that bit and a fresh edge on its event input at the same falling edge. A toggle alone would clear the bit, so a later read must show it still set. The keyed reset meets a held event level in the same way: the bench keeps an event high across the reset and checks that the status afterwards equals the supplied reset value.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_RESET  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_GIE    = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'hC;

  localparam logic [REG_W-1:0] RESET_KEY = 32'h0000_000A;

  typedef struct packed {
    logic gieWr;
    logic statusWr;
    logic enableWr;
    logic softRst;
  } regStrobes_t;

  function automatic logic [REG_W-1:0] implMask(input int nBits);
    logic [2*REG_W-1:0] wide;
    wide = (64'd1 << nBits) - 64'd1;
    return wide[REG_W-1:0];
  endfunction
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output regStrobes_t       strobes
);
  logic softRstQ;
  logic keyHit;

  assign keyHit = wrEn && (addr == OFS_RESET) && (wrData == RESET_KEY);

  // Reset pulse lives for exactly the cycle after the keyed write.
  always_ff @(posedge clk) begin
    if (!rstN) softRstQ <= 1'b0;
    else       softRstQ <= keyHit;
  end

  always_comb begin
    strobes.gieWr    = wrEn && (addr == OFS_GIE);
    strobes.statusWr = wrEn && (addr == OFS_STATUS);
    strobes.enableWr = wrEn && (addr == OFS_ENABLE);
    strobes.softRst  = softRstQ;
  end
endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
  import irq_bank_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [REG_W-1:0]  eventIn,
  input  logic [REG_W-1:0]  statusInit,
  output logic [REG_W-1:0]  statusQ,
  output logic [REG_W-1:0]  enableQ,
  output logic              gieQ,
  output logic [REG_W-1:0]  rdData,
  output logic              irqOut
);
  localparam logic [REG_W-1:0] MASK = implMask(NUM_BITS);

  logic [REG_W-1:0] prevEvtQ;
  logic [REG_W-1:0] riseEvt;
  logic [REG_W-1:0] toggled;
  logic [REG_W-1:0] rdMux;
  logic             anyReset;

  assign anyReset = !rstN || strobes.softRst;
  assign riseEvt  = eventIn & ~prevEvtQ & MASK;
  assign toggled  = strobes.statusWr ? (statusQ ^ wrData) : statusQ;

  // Edge history tracks the inputs even through reset, so a level that
  // was already high does not count as a new event afterwards.
  always_ff @(posedge clk) prevEvtQ <= eventIn & MASK;

  always_ff @(posedge clk) begin
    if (anyReset) begin
      statusQ <= statusInit & MASK;
      enableQ <= '0;
      gieQ    <= 1'b0;
    end else begin
      statusQ <= (toggled | riseEvt) & MASK;
      if (strobes.enableWr) enableQ <= wrData & MASK;
      if (strobes.gieWr)    gieQ    <= wrData[0];
    end
  end

  always_comb begin
    case (addr)
      OFS_GIE:    rdMux = {{(REG_W-1){1'b0}}, gieQ};
      OFS_STATUS: rdMux = statusQ;
      OFS_ENABLE: rdMux = enableQ;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end

  generate
    if (NUM_BITS == 0) begin : gNoBits
      assign irqOut = 1'b0;
    end else begin : gBits
      assign irqOut = gieQ && (|(statusQ & enableQ));
    end
  endgenerate
endmodule

// File: rtl/irq_toggle_bank.sv
module irq_toggle_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [REG_W-1:0]  eventIn,
  input  logic [REG_W-1:0]  statusInit,
  output logic              irqOut
);
  regStrobes_t      strobes;
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] enableQ;
  logic             gieQ;

  irq_bank_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strobes(strobes)
  );

  irq_bank_regs #(.NUM_BITS(NUM_BITS)) uRegs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .eventIn(eventIn), .statusInit(statusInit),
    .statusQ(statusQ), .enableQ(enableQ), .gieQ(gieQ),
    .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_bank_checker.sv
module irq_bank_checker
  import irq_bank_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wrData,
  input logic [REG_W-1:0]  eventIn,
  input logic [REG_W-1:0]  statusInit,
  input logic              irqOut,
  input logic [REG_W-1:0]  statusQ,
  input logic [REG_W-1:0]  enableQ,
  input logic              gieQ,
  input logic              softRst
);
  localparam logic [REG_W-1:0] MASK = implMask(NUM_BITS);

  logic [REG_W-1:0] lastEvt;
  logic [REG_W-1:0] rise;
  logic             statWr;
  logic             keyWr;

  always_ff @(posedge clk) lastEvt <= eventIn;
  assign rise   = eventIn & ~lastEvt & MASK;
  assign statWr = wrEn && (addr == OFS_STATUS);
  assign keyWr  = wrEn && (addr == OFS_RESET) && (wrData == RESET_KEY);

  assert_upper_bits_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ | enableQ) & ~MASK) == '0);

  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !softRst && rise == '0) |=> statusQ == (($past(statusQ) ^ $past(wrData)) & MASK));

  assert_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!statWr && !softRst) |=> (statusQ & $past(statusQ)) == $past(statusQ));

  assert_event_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rise != '0 && !softRst) |=> (statusQ & $past(rise)) == $past(rise));

  assert_irq_gie_R7: assert property (@(posedge clk) disable iff (!rstN)
    !gieQ |-> !irqOut);

  assert_irq_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & enableQ) == '0) |-> !irqOut);

  assert_key_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    keyWr |=> ##1 (enableQ == '0 && !gieQ && statusQ == (statusInit & MASK)));
endmodule

bind irq_toggle_bank irq_bank_checker #(.NUM_BITS(NUM_BITS)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .eventIn(eventIn), .statusInit(statusInit), .irqOut(irqOut),
  .statusQ(statusQ), .enableQ(enableQ), .gieQ(gieQ), .softRst(strobes.softRst)
);

// File: tb/tb_irq_toggle_bank.sv
`timescale 1ns/1ps
module tb_irq_toggle_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] eventIn = '0;
  logic [31:0] statusInit = 32'h0000_0F05;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  irq_toggle_bank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .eventIn(eventIn),
    .statusInit(statusInit), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R7 irq after reset", {31'b0, irqOut}, 32'h0);
    busRead(4'hC, v); check("R2 enable reset", v, 32'h0);
    busRead(4'h8, v); check("R4 status init", v, 32'h05);
    busRead(4'h4, v); check("R7 gie reset", v, 32'h0);
    busRead(4'h0, v); check("R9 reset reg reads 0", v, 32'h0);
  endtask

  task automatic testToggle();
    logic [31:0] v;
    busWrite(4'h8, 32'hF0); busRead(4'h8, v); check("R3 first toggle sets", v, 32'hF5);
    busWrite(4'h8, 32'hF0); busRead(4'h8, v); check("R3 second toggle clears", v, 32'h05);
    busWrite(4'h8, 32'hFFFF_FF05); busRead(4'h8, v); check("R1 upper status ignored", v, 32'h0);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    busWrite(4'hC, 32'hFFFF_FFA5); busRead(4'hC, v); check("R1 R2 enable readback", v, 32'hA5);
    busWrite(4'hC, 32'h12); busRead(4'hC, v); check("R2 enable rewrite", v, 32'h12);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    busWrite(4'hC, 32'h01); busWrite(4'h4, 32'h1);
    check("R7 no pending", {31'b0, irqOut}, 32'h0);
    busWrite(4'h8, 32'h01);
    check("R7 pending enabled", {31'b0, irqOut}, 32'h1);
    busWrite(4'h4, 32'h0);
    check("R7 gie off", {31'b0, irqOut}, 32'h0);
    busWrite(4'h4, 32'h1);
    check("R7 gie on", {31'b0, irqOut}, 32'h1);
    busWrite(4'hC, 32'h0);
    check("R7 bit disabled", {31'b0, irqOut}, 32'h0);
    busRead(4'h4, v); check("R7 gie readback", v, 32'h1);
    busWrite(4'h8, 32'h01); busRead(4'h8, v); check("R3 ack", v, 32'h0);
  endtask

  task automatic testEventLatch();
    logic [31:0] v;
    @(negedge clk); eventIn = 32'h08;
    @(negedge clk); eventIn = 32'h0;
    repeat (4) @(negedge clk);
    busRead(4'h8, v); check("R5 R6 event latched", v, 32'h08);
    @(negedge clk); eventIn = 32'h08;
    repeat (5) @(negedge clk);
    busWrite(4'h8, 32'h08);
    repeat (3) @(negedge clk);
    busRead(4'h8, v); check("R6 steady level no reset", v, 32'h0);
    @(negedge clk); eventIn = 32'h0;
  endtask

  task automatic testCollision();
    logic [31:0] v;
    busWrite(4'h8, 32'h04); busRead(4'h8, v); check("R3 set bit2", v, 32'h04);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'h8; wrData = 32'h04; eventIn = 32'h04;
    @(negedge clk);
    wrEn = 1'b0;
    busRead(4'h8, v); check("R6 event wins collision", v, 32'h04);
    @(negedge clk); eventIn = 32'h0;
  endtask

  task automatic testKeyReset();
    logic [31:0] v;
    busWrite(4'hC, 32'h87); busWrite(4'h4, 32'h1);
    @(negedge clk); eventIn = 32'h80;
    repeat (2) @(negedge clk);
    busRead(4'h8, v); check("R6 bit7 event", v, 32'h84);
    check("R7 irq raised", {31'b0, irqOut}, 32'h1);
    busWrite(4'h0, 32'h5);
    repeat (2) @(negedge clk);
    busRead(4'hC, v); check("R8 wrong key ignored", v, 32'h87);
    busWrite(4'h0, 32'hA);
    @(negedge clk);
    check("R8 irq cleared", {31'b0, irqOut}, 32'h0);
    busRead(4'hC, v); check("R8 enable cleared", v, 32'h0);
    busRead(4'h4, v); check("R8 gie cleared", v, 32'h0);
    busRead(4'h8, v); check("R8 R6 status reloaded", v, 32'h05);
    repeat (3) @(negedge clk);
    check("R9 rdData holds", rdData, 32'h05);
    busRead(4'h2, v); check("R9 unmapped reads 0", v, 32'h0);
    @(negedge clk); eventIn = 32'h0;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testToggle();
    testEnable();
    testIrq();
    testEventLatch();
    testCollision();
    testKeyReset();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule